// File: doc/BRIEF.md
# PCI Interrupt Line Router

This block steers four shared, level-sensitive PCI interrupt request lines onto sixteen legacy interrupt-controller inputs. Each request line has a byte-wide routing code held in a small register window. A code below sixteen names the destination line. A code of sixteen or more turns that request line off. Several request lines may share one destination, and that destination is then the OR of all of them.

The block keeps a 64-bit level map with one bit per (line, request) pair. Because of this map, a shared destination stays correct while routes are rewritten. A write that touches any routing byte clears the map and rebuilds it from the new codes and the present input levels.

A separate query port takes a device/function number and an INTx pin. It returns which request line that pin is wired to, and whether and where that request line is currently routed.

Top module: `pirq_line_router`

## Requirements
- R1: After reset every routing byte reads 0x80, all sixteen outputs are low and the level map is empty.
- R2: The routing bytes occupy the 32-bit word at byte address 0x60. Byte lane b (bits 8b+7:8b) holds the code of request line b, with A=0 through D=3. Only lanes whose byte enable is set are written, and writes to any other word change nothing. A read returns data one cycle after `reg_rd` and gives 0 for any other word.
- R3: A read returns each stored code unchanged, including codes of 16 or more.
- R4: A request line whose code is below 16 drives output line number `code`. A level change on the input appears on the output after the second rising edge.
- R5: A request line whose code is 16 or more has no effect on any output.
- R6: Each output is high exactly when at least one request line routed to it is high, so no more outputs are high than request inputs.
- R7: A write to any routing byte rebuilds the map from the new codes and the current levels. The outputs reflect this one cycle after the write edge, and a line that lost its source drops.
- R8: The query gives `q_pirq = (q_intx + (q_devfn >> 3) - 1) mod 4`, where INTA=0 through INTD=3, registered one cycle after the inputs.
- R9: The query reports `q_en`=1 and `q_line`=code when the selected request line's code is below 16. Otherwise it reports `q_en`=0 and `q_line`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Byte address, word aligned |
| reg_wdata | input | 32 | Write data, one routing byte per lane |
| reg_be | input | 4 | Byte enables for the write |
| reg_rdata | output | 32 | Registered read data |
| pirq_lvl | input | 4 | Request line levels, bit 0 = A |
| irq_out | output | 16 | Interrupt-controller input levels |
| q_devfn | input | 8 | Device/function number for the query |
| q_intx | input | 2 | INTx pin for the query, 0 = INTA |
| q_pirq | output | 2 | Request line the pin is wired to |
| q_en | output | 1 | Selected request line is routed |
| q_line | output | 4 | Destination line when routed, else 0 |

## Verification
The assertions take it for granted that the request levels and the routing codes come only through the ports. On that basis, any high output can be traced to a request input that was high two edges earlier, and a set of routes that has been off for two cycles keeps every output low. They also assume reads and writes are never strobed in the same cycle on the routing word. The stimulus keeps to this by issuing one operation at a time, each on a falling edge, and by mixing random live codes, random off codes (16 to 255) and random level patterns with directed sharing, rerouting and byte-enable cases.

// File: rtl/pirq_route_pkg.sv
package pirq_route_pkg;

  localparam int CODE_W = 8;
  localparam logic [CODE_W-1:0] CODE_OFF = 8'h80;

  typedef logic [CODE_W-1:0] route_code_t;

  // A code is live when it names one of the available lines.
  function automatic logic code_live(input route_code_t code, input int n_lines);
    return int'(code) < n_lines;
  endfunction

endpackage

// File: rtl/pirq_route_regs.sv
module pirq_route_regs
  import pirq_route_pkg::*;
#(
  parameter int NUM_PIRQ = 4,
  parameter int ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] ROUTE_BASE = 8'h60
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          reg_wr,
  input  logic                          reg_rd,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [NUM_PIRQ*CODE_W-1:0]    reg_wdata,
  input  logic [NUM_PIRQ-1:0]           reg_be,
  output logic [NUM_PIRQ*CODE_W-1:0]    reg_rdata,
  output logic [NUM_PIRQ-1:0][CODE_W-1:0] route_q,
  output logic [NUM_PIRQ-1:0][CODE_W-1:0] route_d,
  output logic                          rebuild
);

  localparam int SEL_W = $clog2(NUM_PIRQ);

  logic win_hit;

  assign win_hit = (reg_addr >> SEL_W) == (ROUTE_BASE >> SEL_W);

  // Next routing codes and the rebuild request for the level map.
  always_comb begin
    route_d = route_q;
    rebuild = 1'b0;
    if (reg_wr && win_hit) begin
      for (int b = 0; b < NUM_PIRQ; b++) begin
        if (reg_be[b]) begin
          route_d[b] = reg_wdata[b*CODE_W +: CODE_W];
          rebuild    = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      route_q <= {NUM_PIRQ{CODE_OFF}};
    end else begin
      route_q <= route_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= win_hit ? route_q : '0;
    end
  end

endmodule

// File: rtl/pirq_level_map.sv
module pirq_level_map
  import pirq_route_pkg::*;
#(
  parameter int NUM_PIRQ  = 4,
  parameter int NUM_LINES = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            rebuild,
  input  logic [NUM_PIRQ-1:0][CODE_W-1:0] route_q,
  input  logic [NUM_PIRQ-1:0][CODE_W-1:0] route_d,
  input  logic [NUM_PIRQ-1:0]             pirq_lvl,
  output logic [NUM_LINES-1:0]            irq_out
);

  localparam int LINE_W = $clog2(NUM_LINES);
  localparam int MAP_W  = NUM_PIRQ * NUM_LINES;

  logic [MAP_W-1:0]     map_q;
  logic [MAP_W-1:0]     map_d;
  logic [NUM_LINES-1:0] line_any;

  // Bit (line*NUM_PIRQ + pirq) holds the level of pirq seen on line.
  always_comb begin
    map_d = map_q;
    if (rebuild) begin
      map_d = '0;
      for (int p = 0; p < NUM_PIRQ; p++) begin
        if (code_live(route_d[p], NUM_LINES)) begin
          map_d[int'(route_d[p][LINE_W-1:0]) * NUM_PIRQ + p] = pirq_lvl[p];
        end
      end
    end else begin
      for (int p = 0; p < NUM_PIRQ; p++) begin
        if (code_live(route_q[p], NUM_LINES)) begin
          map_d[int'(route_q[p][LINE_W-1:0]) * NUM_PIRQ + p] = pirq_lvl[p];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      map_q <= '0;
    end else begin
      map_q <= map_d;
    end
  end

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    assign line_any[l] = |map_q[l*NUM_PIRQ +: NUM_PIRQ];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out <= '0;
    end else begin
      irq_out <= line_any;
    end
  end

endmodule

// File: rtl/pirq_pin_query.sv
module pirq_pin_query
  import pirq_route_pkg::*;
#(
  parameter int NUM_PIRQ  = 4,
  parameter int NUM_LINES = 16
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [7:0]                      q_devfn,
  input  logic [$clog2(NUM_PIRQ)-1:0]     q_intx,
  input  logic [NUM_PIRQ-1:0][CODE_W-1:0] route_q,
  output logic [$clog2(NUM_PIRQ)-1:0]     q_pirq,
  output logic                            q_en,
  output logic [$clog2(NUM_LINES)-1:0]    q_line
);

  localparam int PIRQ_W = $clog2(NUM_PIRQ);
  localparam int LINE_W = $clog2(NUM_LINES);

  logic [PIRQ_W-1:0] pirq_c;
  route_code_t       code_c;
  logic              live_c;

  // Rotate the pin by the slot number, with slot 1 mapping INTA to A.
  assign pirq_c = PIRQ_W'((int'(q_devfn) / 8 + int'(q_intx) + NUM_PIRQ - 1) % NUM_PIRQ);
  assign code_c = route_q[pirq_c];
  assign live_c = code_live(code_c, NUM_LINES);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_pirq <= '0;
      q_en   <= 1'b0;
      q_line <= '0;
    end else begin
      q_pirq <= pirq_c;
      q_en   <= live_c;
      q_line <= live_c ? code_c[LINE_W-1:0] : '0;
    end
  end

endmodule

// File: rtl/pirq_line_router.sv
module pirq_line_router
  import pirq_route_pkg::*;
#(
  parameter int NUM_PIRQ  = 4,
  parameter int NUM_LINES = 16,
  parameter int ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] ROUTE_BASE = 8'h60
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          reg_wr,
  input  logic                          reg_rd,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [NUM_PIRQ*8-1:0]         reg_wdata,
  input  logic [NUM_PIRQ-1:0]           reg_be,
  output logic [NUM_PIRQ*8-1:0]         reg_rdata,
  input  logic [NUM_PIRQ-1:0]           pirq_lvl,
  output logic [NUM_LINES-1:0]          irq_out,
  input  logic [7:0]                    q_devfn,
  input  logic [$clog2(NUM_PIRQ)-1:0]   q_intx,
  output logic [$clog2(NUM_PIRQ)-1:0]   q_pirq,
  output logic                          q_en,
  output logic [$clog2(NUM_LINES)-1:0]  q_line
);

  logic [NUM_PIRQ-1:0][CODE_W-1:0] route_q;
  logic [NUM_PIRQ-1:0][CODE_W-1:0] route_d;
  logic                            rebuild;

  pirq_route_regs #(
    .NUM_PIRQ   (NUM_PIRQ),
    .ADDR_W     (ADDR_W),
    .ROUTE_BASE (ROUTE_BASE)
  ) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_be    (reg_be),
    .reg_rdata (reg_rdata),
    .route_q   (route_q),
    .route_d   (route_d),
    .rebuild   (rebuild)
  );

  pirq_level_map #(
    .NUM_PIRQ  (NUM_PIRQ),
    .NUM_LINES (NUM_LINES)
  ) u_map (
    .clk      (clk),
    .rst      (rst),
    .rebuild  (rebuild),
    .route_q  (route_q),
    .route_d  (route_d),
    .pirq_lvl (pirq_lvl),
    .irq_out  (irq_out)
  );

  pirq_pin_query #(
    .NUM_PIRQ  (NUM_PIRQ),
    .NUM_LINES (NUM_LINES)
  ) u_query (
    .clk     (clk),
    .rst     (rst),
    .q_devfn (q_devfn),
    .q_intx  (q_intx),
    .route_q (route_q),
    .q_pirq  (q_pirq),
    .q_en    (q_en),
    .q_line  (q_line)
  );

endmodule

// File: rtl/pirq_line_router_chk.sv
module pirq_line_router_chk
  import pirq_route_pkg::*;
#(
  parameter int NUM_PIRQ  = 4,
  parameter int NUM_LINES = 16,
  parameter int ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] ROUTE_BASE = 8'h60
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            reg_rd,
  input logic [ADDR_W-1:0]               reg_addr,
  input logic [NUM_PIRQ*8-1:0]           reg_rdata,
  input logic [NUM_PIRQ-1:0]             pirq_lvl,
  input logic [NUM_LINES-1:0]            irq_out,
  input logic [NUM_PIRQ-1:0][CODE_W-1:0] route_q,
  input logic                            q_en,
  input logic [$clog2(NUM_LINES)-1:0]    q_line
);

  localparam int SEL_W = $clog2(NUM_PIRQ);

  logic all_off;
  logic outside;

  always_comb begin
    all_off = 1'b1;
    for (int p = 0; p < NUM_PIRQ; p++) begin
      if (code_live(route_q[p], NUM_LINES)) all_off = 1'b0;
    end
  end

  assign outside = (reg_addr >> SEL_W) != (ROUTE_BASE >> SEL_W);

  // R1: reset leaves outputs and read data clear
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (irq_out == '0 && reg_rdata == '0 && !q_en));

  // R2: reads outside the routing word return zero
  a_r2_outside_zero: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && outside) |=> (reg_rdata == '0));

  // R5: with every route off for two cycles no output is high
  a_r5_off_quiet: assert property (@(posedge clk) disable iff (rst)
    (all_off && $past(all_off) && $past(all_off, 2)) |-> (irq_out == '0));

  // R6: a high output needs a high request two edges before
  a_r6_needs_source: assert property (@(posedge clk) disable iff (rst)
    (|irq_out) |-> $past(|pirq_lvl, 2));

  // R6: never more lines high than requests high
  a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
    $countones(irq_out) <= $countones($past(pirq_lvl, 2)));

  // R9: an unrouted query reports line zero
  a_r9_off_line_zero: assert property (@(posedge clk) disable iff (rst)
    !q_en |-> (q_line == '0));

endmodule

bind pirq_line_router pirq_line_router_chk #(
  .NUM_PIRQ   (NUM_PIRQ),
  .NUM_LINES  (NUM_LINES),
  .ADDR_W     (ADDR_W),
  .ROUTE_BASE (ROUTE_BASE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .reg_rd    (reg_rd),
  .reg_addr  (reg_addr),
  .reg_rdata (reg_rdata),
  .pirq_lvl  (pirq_lvl),
  .irq_out   (irq_out),
  .route_q   (route_q),
  .q_en      (q_en),
  .q_line    (q_line)
);

// File: tb/pirq_line_router_bench.sv
module pirq_line_router_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  reg_be = '0;
  logic [31:0] reg_rdata;
  logic [3:0]  pirq_lvl = '0;
  logic [15:0] irq_out;
  logic [7:0]  q_devfn = '0;
  logic [1:0]  q_intx = '0;
  logic [1:0]  q_pirq;
  logic        q_en;
  logic [3:0]  q_line;

  int checks = 0;
  int errors = 0;

  logic [3:0][7:0] m_rt;
  logic [3:0]      m_lv;

  always #10 clk = ~clk;

  pirq_line_router u_pirq_line_router (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_be(reg_be),
    .reg_rdata(reg_rdata), .pirq_lvl(pirq_lvl), .irq_out(irq_out),
    .q_devfn(q_devfn), .q_intx(q_intx), .q_pirq(q_pirq),
    .q_en(q_en), .q_line(q_line)
  );

  function automatic logic [15:0] exp_lines(input logic [3:0][7:0] rt, input logic [3:0] lv);
    logic [15:0] r = '0;
    for (int p = 0; p < 4; p++)
      if (rt[p] < 8'd16 && lv[p]) r[rt[p][3:0]] = 1'b1;
    return r;
  endfunction

  function automatic logic [1:0] exp_pirq(input logic [7:0] devfn, input logic [1:0] intx);
    return 2'((int'(intx) + int'(devfn >> 3) + 3) % 4);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d; reg_be = be;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = '0;
    if (a[7:2] == 6'h18)
      for (int b = 0; b < 4; b++) if (be[b]) m_rt[b] = d[b*8 +: 8];
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic lvl(input logic [3:0] v);
    @(negedge clk);
    pirq_lvl = v; m_lv = v;
  endtask

  task automatic settle_check(input string tag);
    repeat (2) @(negedge clk);
    chk(tag, {16'h0, irq_out}, {16'h0, exp_lines(m_rt, m_lv)});
  endtask

  task automatic query_check(input logic [7:0] dv, input logic [1:0] ix);
    logic [1:0] ep;
    @(negedge clk);
    q_devfn = dv; q_intx = ix;
    @(negedge clk);
    ep = exp_pirq(dv, ix);
    chk("R8 swizzle", {30'h0, q_pirq}, {30'h0, ep});
    chk("R9 query enable", {31'h0, q_en}, {31'h0, m_rt[ep] < 8'd16});
    chk("R9 query line", {28'h0, q_line}, {28'h0, (m_rt[ep] < 8'd16) ? m_rt[ep][3:0] : 4'h0});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] r;
    m_rt = {4{8'h80}};
    m_lv = '0;
    r = $urandom(32'h5EED1);
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 outputs after reset", {16'h0, irq_out}, 32'h0);
    rd(8'h60, d);
    chk("R1 routing bytes after reset", d, 32'h80808080);

    // R4 single route
    wr(8'h60, 32'h0000_0005, 4'b0001);
    lvl(4'b0001);
    settle_check("R4 route A to line 5");
    chk("R4 line 5 high", {31'h0, irq_out[5]}, 32'h1);

    // R6 shared line
    wr(8'h60, 32'h0000_0500, 4'b0010);
    lvl(4'b0010);
    settle_check("R6 B alone on shared line");
    lvl(4'b0011);
    settle_check("R6 both on shared line");
    lvl(4'b0000);
    settle_check("R6 shared line released");

    // R5 and R3 disabled code
    wr(8'h60, 32'h009A_0000, 4'b0100);
    lvl(4'b0100);
    settle_check("R5 disabled C ignored");
    chk("R5 no line high", {16'h0, irq_out}, 32'h0);
    rd(8'h60, d);
    chk("R3 stored codes readback", d, 32'h809A0505);

    // R7 reroute rebuild with a held level
    lvl(4'b0001);
    settle_check("R7 before reroute");
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 8'h60; reg_wdata = 32'h0000_0009; reg_be = 4'b0001;
    @(negedge clk);
    reg_wr = 1'b0; reg_be = '0; m_rt[0] = 8'h09;
    @(negedge clk);
    chk("R7 rebuilt one cycle after write", {16'h0, irq_out}, 32'h0000_0200);

    // R2 byte enables and address decode
    wr(8'h60, 32'h0303_0303, 4'b0000);
    wr(8'h64, 32'h0101_0101, 4'b1111);
    wr(8'h5C, 32'h0202_0202, 4'b1111);
    rd(8'h60, d);
    chk("R2 no-enable and foreign writes ignored", d, 32'h809A0509);
    rd(8'h64, d);
    chk("R2 foreign word reads zero", d, 32'h0);
    wr(8'h62, 32'h0C00_0000, 4'b1000);
    rd(8'h60, d);
    chk("R2 lane D written via sub-word address", d, 32'h0C9A0509);
    lvl(4'b1000);
    settle_check("R4 D to line 12");

    // R8 R9 directed swizzle
    query_check(8'h08, 2'd0);
    query_check(8'h00, 2'd0);
    query_check(8'h1F, 2'd3);
    query_check(8'hF8, 2'd2);

    // Random mix
    for (int i = 0; i < 300; i++) begin
      r = $urandom;
      if (r[1:0] == 2'd0) begin
        logic [31:0] wd;
        for (int b = 0; b < 4; b++)
          wd[b*8 +: 8] = ($urandom % 3 == 0) ? 8'(16 + $urandom % 240) : 8'($urandom % 16);
        wr(8'h60, wd, 4'($urandom));
        settle_check("R7 random reroute");
      end else if (r[1:0] == 2'd1) begin
        rd(8'h60, d);
        chk("R3 random readback", d, m_rt);
      end else if (r[1:0] == 2'd2) begin
        query_check(8'($urandom), 2'($urandom));
      end else begin
        lvl(4'($urandom));
        settle_check("R6 random levels");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule